// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This block settles where a 16-bit processor fetches next once a control-flow instruction reaches it. It reads the 7-bit opcode, the zero and less-than status flags, the current program counter, the word that follows the instruction, and a register value. From these it produces the next program counter and reports whether a branch or jump was taken. For jump-and-link it also raises a write enable and supplies the data for the return-address register. The program counter is held in a register inside the block. It loads the resolved address on every clock edge where `resolve_valid` is high, and keeps its value otherwise.

Four conditional branches test the zero flag, the less-than flag, or both. A taken branch adds the following word, treated as a two's-complement displacement, to the address of the branch instruction. A branch that is not taken skips both the instruction and its displacement word. Absolute jump and jump-and-link take their target from the following word. Jump-to-register takes its target from the register value. Any other opcode advances the counter by one 16-bit instruction. Fetching the displacement word and the register file itself are handled by neighbouring logic.

Top module: `bru_unit`

## Requirements
- R1: While `rst_n` is low, the registered `pc_q` is set to RESET_PC (default 0x0000). After reset, `taken` and `link_we` are 0 whenever `resolve_valid` is 0.
- R2: Opcode 7'b1110000 (branch if equal) is taken exactly when `flag_zero` is 1. When taken, `next_pc` = `pc_q` + `disp_word`.
- R3: Opcode 7'b1110001 (branch if not equal) is taken exactly when `flag_zero` is 0. When taken, `next_pc` = `pc_q` + `disp_word`.
- R4: Opcode 7'b1110010 (branch if less) is taken exactly when `flag_less` is 1. When taken, `next_pc` = `pc_q` + `disp_word`.
- R5: Opcode 7'b1110011 (branch if greater) is taken exactly when `flag_less` and `flag_zero` are both 0. When taken, `next_pc` = `pc_q` + `disp_word`.
- R6: A conditional branch that is not taken gives `taken` = 0 and `next_pc` = `pc_q` + 4.
- R7: Any opcode whose top three bits are 3'b100 is an absolute jump: `taken` = 1 and `next_pc` = `disp_word`.
- R8: Any opcode whose top three bits are 3'b011 is a jump-and-link: `taken` = 1, `next_pc` = `disp_word`, `link_we` = 1 and `link_data` = `pc_q` + 2. No other opcode raises `link_we`.
- R9: Any opcode whose top three bits are 3'b010 is a jump to register: `taken` = 1 and `next_pc` = `reg_value`.
- R10: Every other opcode advances the counter by one instruction, with `taken` = 0, `link_we` = 0 and `next_pc` = `pc_q` + 2. This covers 0000000, arithmetic opcodes, and the unused 11101xx and 11110xx codes.
- R11: On a rising edge with `resolve_valid` = 1, `pc_q` takes the value `next_pc` showed before that edge. With `resolve_valid` = 0, `pc_q` holds and `next_pc` equals `pc_q`.
- R12: All address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| resolve_valid | input | 1 | The inputs describe an instruction to resolve this cycle |
| opcode | input | 7 | Opcode field of the instruction |
| flag_zero | input | 1 | Zero status flag |
| flag_less | input | 1 | Less-than status flag |
| disp_word | input | 16 | Word after the instruction: a displacement or an absolute target |
| reg_value | input | 16 | Value of the register named by a jump to register |
| pc_q | output | 16 | Registered program counter |
| next_pc | output | 16 | Resolved next program counter |
| taken | output | 1 | Control transfer taken |
| link_we | output | 1 | Write enable for the return-address register |
| link_data | output | 16 | Return address to write |

## Verification
Each conditional opcode is applied with both a flag setting that makes it taken and one that does not. The greater-than branch is also applied with only the less-than flag set and with only the zero flag set. These pairs separate a correct condition from one that is inverted, uses the wrong flag, or uses the wrong combination of flags. Displacements of both signs, and counters close to 0xFFFF, show whether the sign is handled and the sum wraps. Each jump class gets a target that differs from every sequential address, so a wrongly decoded jump stands out. Undefined and arithmetic opcodes, together with an idle cycle that carries a jump opcode, show that nothing outside the control class moves the counter or writes the link register.

// File: rtl/bru_pkg.sv
package bru_pkg;

    // Class of control-flow behaviour selected by the opcode
    typedef enum logic [2:0] {
        KIND_SEQ   = 3'd0,
        KIND_COND  = 3'd1,
        KIND_JABS  = 3'd2,
        KIND_JLINK = 3'd3,
        KIND_JREG  = 3'd4
    } kind_e;

    // Condition code in the two low opcode bits of a conditional branch
    typedef enum logic [1:0] {
        COND_EQ = 2'd0,
        COND_NE = 2'd1,
        COND_LT = 2'd2,
        COND_GT = 2'd3
    } cond_e;

    typedef struct packed {
        kind_e kind;
        cond_e cond;
    } dec_t;

endpackage

// File: rtl/bru_decode.sv
module bru_decode
    import bru_pkg::*;
#(
    parameter int OPW = 7
) (
    input  logic [OPW-1:0] opcode,
    output dec_t           dec
);
    localparam int TOP = OPW - 1;

    logic [2:0] grp;
    logic [4:0] cgrp;

    always_comb begin
        grp      = opcode[TOP -: 3];
        cgrp     = opcode[TOP -: 5];
        dec.cond = cond_e'(opcode[1:0]);
        unique case (grp)
            3'b100:  dec.kind = KIND_JABS;
            3'b011:  dec.kind = KIND_JLINK;
            3'b010:  dec.kind = KIND_JREG;
            3'b111:  dec.kind = (cgrp == 5'b11100) ? KIND_COND : KIND_SEQ;
            default: dec.kind = KIND_SEQ;
        endcase
    end

endmodule

// File: rtl/bru_cond.sv
module bru_cond
    import bru_pkg::*;
(
    input  cond_e cond,
    input  logic  flag_zero,
    input  logic  flag_less,
    output logic  met
);
    always_comb begin
        unique case (cond)
            COND_EQ: met = flag_zero;
            COND_NE: met = ~flag_zero;
            COND_LT: met = flag_less;
            COND_GT: met = ~flag_less & ~flag_zero;
            default: met = 1'b0;
        endcase
    end

endmodule

// File: rtl/bru_target.sv
module bru_target
    import bru_pkg::*;
#(
    parameter int AW   = 16,
    parameter int STEP = 2
) (
    input  kind_e         kind,
    input  logic          met,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] disp,
    input  logic [AW-1:0] regv,
    output logic [AW-1:0] target,
    output logic          xfer,
    output logic          link,
    output logic [AW-1:0] ret_addr
);
    localparam logic [AW-1:0] SEQ_INC  = AW'(STEP);
    localparam logic [AW-1:0] SKIP_INC = AW'(2 * STEP);

    logic [AW-1:0] pc_seq;
    logic [AW-1:0] pc_skip;
    logic [AW-1:0] pc_rel;

    // Three adders run in parallel so only a mux follows them
    always_comb begin
        pc_seq  = pc + SEQ_INC;
        pc_skip = pc + SKIP_INC;
        pc_rel  = pc + disp;
    end

    always_comb begin
        target   = pc_seq;
        xfer     = 1'b0;
        link     = 1'b0;
        ret_addr = pc_seq;
        unique case (kind)
            KIND_COND: begin
                target = met ? pc_rel : pc_skip;
                xfer   = met;
            end
            KIND_JABS: begin
                target = disp;
                xfer   = 1'b1;
            end
            KIND_JLINK: begin
                target = disp;
                xfer   = 1'b1;
                link   = 1'b1;
            end
            KIND_JREG: begin
                target = regv;
                xfer   = 1'b1;
            end
            default: begin
                target = pc_seq;
            end
        endcase
    end

endmodule

// File: rtl/bru_unit.sv
module bru_unit
    import bru_pkg::*;
#(
    parameter int             AW       = 16,
    parameter int             OPW      = 7,
    parameter int             STEP     = 2,
    parameter logic [AW-1:0]  RESET_PC = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           resolve_valid,
    input  logic [OPW-1:0] opcode,
    input  logic           flag_zero,
    input  logic           flag_less,
    input  logic [AW-1:0]  disp_word,
    input  logic [AW-1:0]  reg_value,
    output logic [AW-1:0]  pc_q,
    output logic [AW-1:0]  next_pc,
    output logic           taken,
    output logic           link_we,
    output logic [AW-1:0]  link_data
);
    typedef struct packed {
        logic [AW-1:0] pc;
    } state_t;

    state_t st_d;
    state_t st_q;

    dec_t          dec;
    logic          met;
    logic [AW-1:0] target;
    logic          xfer;
    logic          link;
    logic [AW-1:0] ret_addr;

    bru_decode #(.OPW(OPW)) u_decode (
        .opcode (opcode),
        .dec    (dec)
    );

    bru_cond u_cond (
        .cond      (dec.cond),
        .flag_zero (flag_zero),
        .flag_less (flag_less),
        .met       (met)
    );

    bru_target #(.AW(AW), .STEP(STEP)) u_target (
        .kind     (dec.kind),
        .met      (met),
        .pc       (st_q.pc),
        .disp     (disp_word),
        .regv     (reg_value),
        .target   (target),
        .xfer     (xfer),
        .link     (link),
        .ret_addr (ret_addr)
    );

    always_comb begin
        st_d = st_q;
        if (resolve_valid) begin
            st_d.pc = target;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_q      = st_q.pc;
    assign next_pc   = st_d.pc;
    assign taken     = resolve_valid & xfer;
    assign link_we   = resolve_valid & link;
    assign link_data = ret_addr;

endmodule

// File: rtl/bru_unit_chk.sv
module bru_unit_chk #(
    parameter int AW  = 16,
    parameter int OPW = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           resolve_valid,
    input logic [OPW-1:0] opcode,
    input logic           flag_zero,
    input logic [AW-1:0]  disp_word,
    input logic [AW-1:0]  reg_value,
    input logic [AW-1:0]  pc_q,
    input logic [AW-1:0]  next_pc,
    input logic           taken,
    input logic           link_we,
    input logic [AW-1:0]  link_data
);
    localparam logic [AW-1:0] TWO  = AW'(2);
    localparam logic [AW-1:0] FOUR = AW'(4);

    logic [6:0] op7;
    logic [AW-1:0] pc_plus2;
    logic [AW-1:0] pc_plus4;
    logic [AW-1:0] pc_rel;
    assign op7      = opcode[OPW-1 -: 7];
    assign pc_plus2 = pc_q + TWO;
    assign pc_plus4 = pc_q + FOUR;
    assign pc_rel   = pc_q + disp_word;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !resolve_valid |-> (!taken && !link_we && next_pc == pc_q));

    p_beq_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && op7 == 7'b1110000 && flag_zero) |-> (taken && next_pc == pc_rel));

    p_cond_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && op7[6:2] == 5'b11100 && !taken) |-> (next_pc == pc_plus4));

    p_link_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (resolve_valid && op7[6:4] == 3'b011 && link_data == pc_plus2));

    p_jreg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && op7[6:4] == 3'b010) |-> (taken && next_pc == reg_value));

    p_pc_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resolve_valid |=> (pc_q == $past(next_pc)));

    p_pc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !resolve_valid |=> $stable(pc_q));

endmodule

bind bru_unit bru_unit_chk #(.AW(AW), .OPW(OPW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .resolve_valid (resolve_valid),
    .opcode        (opcode),
    .flag_zero     (flag_zero),
    .disp_word     (disp_word),
    .reg_value     (reg_value),
    .pc_q          (pc_q),
    .next_pc       (next_pc),
    .taken         (taken),
    .link_we       (link_we),
    .link_data     (link_data)
);

// File: tb/bru_unit_bench.sv
module bru_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        resolve_valid = 1'b0;
    logic [6:0]  opcode = 7'b0;
    logic        flag_zero = 1'b0;
    logic        flag_less = 1'b0;
    logic [15:0] disp_word = 16'h0;
    logic [15:0] reg_value = 16'h0;
    logic [15:0] pc_q;
    logic [15:0] next_pc;
    logic        taken;
    logic        link_we;
    logic [15:0] link_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bru_unit u_bru_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .resolve_valid (resolve_valid),
        .opcode        (opcode),
        .flag_zero     (flag_zero),
        .flag_less     (flag_less),
        .disp_word     (disp_word),
        .reg_value     (reg_value),
        .pc_q          (pc_q),
        .next_pc       (next_pc),
        .taken         (taken),
        .link_we       (link_we),
        .link_data     (link_data)
    );

    typedef struct packed {
        logic [15:0] start;
        logic [6:0]  op;
        logic        z;
        logic        l;
        logic [15:0] disp;
        logic [15:0] regv;
        logic [15:0] exp_pc;
        logic        exp_tk;
        logic        exp_lwe;
        logic [15:0] exp_ld;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{16'h0100, 7'b1110000, 1'b1, 1'b0, 16'h0020, 16'h0, 16'h0120, 1'b1, 1'b0, 16'h0, 8'd2},  // R2 taken
        '{16'h0100, 7'b1110000, 1'b0, 1'b1, 16'h0020, 16'h0, 16'h0104, 1'b0, 1'b0, 16'h0, 8'd6},  // R6 beq not taken
        '{16'h0200, 7'b1110001, 1'b0, 1'b1, 16'hFFF0, 16'h0, 16'h01F0, 1'b1, 1'b0, 16'h0, 8'd3},  // R3 negative disp
        '{16'h0200, 7'b1110001, 1'b1, 1'b0, 16'hFFF0, 16'h0, 16'h0204, 1'b0, 1'b0, 16'h0, 8'd6},  // R6 bne not taken
        '{16'h0300, 7'b1110010, 1'b0, 1'b1, 16'h0010, 16'h0, 16'h0310, 1'b1, 1'b0, 16'h0, 8'd4},  // R4 taken
        '{16'h0300, 7'b1110010, 1'b1, 1'b0, 16'h0010, 16'h0, 16'h0304, 1'b0, 1'b0, 16'h0, 8'd6},  // R6 blt not taken
        '{16'h0400, 7'b1110011, 1'b0, 1'b0, 16'h0008, 16'h0, 16'h0408, 1'b1, 1'b0, 16'h0, 8'd5},  // R5 taken
        '{16'h0400, 7'b1110011, 1'b1, 1'b0, 16'h0008, 16'h0, 16'h0404, 1'b0, 1'b0, 16'h0, 8'd5},  // R5 zero set
        '{16'h0400, 7'b1110011, 1'b0, 1'b1, 16'h0008, 16'h0, 16'h0404, 1'b0, 1'b0, 16'h0, 8'd5},  // R5 less set
        '{16'h0500, 7'b1000101, 1'b0, 1'b0, 16'h2500, 16'h0, 16'h2500, 1'b1, 1'b0, 16'h0, 8'd7},  // R7 jump
        '{16'h0600, 7'b0111010, 1'b1, 1'b1, 16'h1234, 16'h0, 16'h1234, 1'b1, 1'b1, 16'h0602, 8'd8}, // R8 link
        '{16'h0700, 7'b0101111, 1'b0, 1'b0, 16'h4444, 16'hABCE, 16'hABCE, 1'b1, 1'b0, 16'h0, 8'd9}, // R9
        '{16'h0800, 7'b0000000, 1'b1, 1'b1, 16'h0040, 16'h0, 16'h0802, 1'b0, 1'b0, 16'h0, 8'd10}, // R10 nop
        '{16'h0900, 7'b1110100, 1'b1, 1'b1, 16'h0040, 16'h0, 16'h0902, 1'b0, 1'b0, 16'h0, 8'd10}, // R10 unused
        '{16'h0A00, 7'b0000001, 1'b0, 1'b0, 16'h0040, 16'h0, 16'h0A02, 1'b0, 1'b0, 16'h0, 8'd10}, // R10 add
        '{16'hFFFE, 7'b0000000, 1'b0, 1'b0, 16'h0000, 16'h0, 16'h0000, 1'b0, 1'b0, 16'h0, 8'd12}, // R12 seq wrap
        '{16'hFFF0, 7'b1110000, 1'b1, 1'b0, 16'h0020, 16'h0, 16'h0010, 1'b1, 1'b0, 16'h0, 8'd12}, // R12 rel wrap
        '{16'hFFFE, 7'b1110001, 1'b1, 1'b0, 16'h0020, 16'h0, 16'h0002, 1'b0, 1'b0, 16'h0, 8'd12}, // R12 skip wrap
        '{16'hFFFE, 7'b0110000, 1'b0, 1'b0, 16'h0040, 16'h0, 16'h0040, 1'b1, 1'b1, 16'h0000, 8'd12} // R12 link wrap
    };

    task automatic chk(input string what, input int req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Moves pc_q to a chosen value with a jump to register
    task automatic set_pc(input logic [15:0] v);
        @(negedge clk);
        resolve_valid = 1'b1;
        opcode        = 7'b0100000;
        reg_value     = v;
        @(posedge clk);
        #1;
        resolve_valid = 1'b0;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset value and idle outputs
        chk("reset pc", 1, pc_q, 16'h0000);
        chk("reset taken", 1, {15'b0, taken}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            set_pc(VECS[i].start);
            @(negedge clk);
            resolve_valid = 1'b1;
            opcode        = VECS[i].op;
            flag_zero     = VECS[i].z;
            flag_less     = VECS[i].l;
            disp_word     = VECS[i].disp;
            reg_value     = VECS[i].regv;
            #2;
            chk("next_pc", int'(VECS[i].req), next_pc, VECS[i].exp_pc);
            chk("taken", int'(VECS[i].req), {15'b0, taken}, {15'b0, VECS[i].exp_tk});
            chk("link_we", int'(VECS[i].req), {15'b0, link_we}, {15'b0, VECS[i].exp_lwe});
            if (VECS[i].exp_lwe)
                chk("link_data", int'(VECS[i].req), link_data, VECS[i].exp_ld);
            @(posedge clk);
            #1;
            // R11: loaded on the edge
            chk("pc_q after edge", 11, pc_q, VECS[i].exp_pc);
            resolve_valid = 1'b0;
        end

        // R11 and R1: an idle cycle carrying a jump-and-link changes nothing
        set_pc(16'h3000);
        @(negedge clk);
        resolve_valid = 1'b0;
        opcode        = 7'b0110000;
        disp_word     = 16'h7777;
        #2;
        chk("idle taken", 1, {15'b0, taken}, 16'h0);
        chk("idle link_we", 8, {15'b0, link_we}, 16'h0);
        chk("idle next_pc", 11, next_pc, 16'h3000);
        @(posedge clk);
        #1;
        chk("idle hold", 11, pc_q, 16'h3000);

        // R1: reset in mid-run returns the counter to its start value
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("mid-run reset", 1, pc_q, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule